// File: doc/BRIEF.md
# Block Cipher Chaining Mode Controller

This controller sits between a data stream and a 128-bit block cipher core and turns that core into a chained-mode engine. The cipher itself is external. The controller hands it one block through a start/done handshake. It takes plaintext or ciphertext blocks on a valid/ready input and returns results on a valid/ready output. It applies one of four chaining schemes around each cipher call: electronic codebook, cipher block chaining (both directions), counter mode, and CMAC tag generation. For CMAC it derives the two subkeys on its own and handles padding of the final block.

Software configures the block through a small write-only register port that a bus slave shim can drive. The port holds the mode, the direction, an interrupt enable, a write-one-to-clear completion status bit, and the 128-bit IV or initial counter. The block has an interrupt line for completed output blocks. It also has a DMA request line that is high whenever the block can take an input or has an output waiting.

Top module: `blkchain_ctrl`

## Requirements
- R1: Mode 0 (electronic codebook) outputs E(x) for each input x when the decrypt bit is 0, and D(x) when it is 1. Register map: address 0 is control, with bits [1:0] mode (0 codebook, 1 CBC, 2 counter, 3 CMAC), bit 2 decrypt, and bit 3 interrupt enable.
- R2: Mode 1 with decrypt 0 outputs E(x XOR c), where c is the IV for the first block and the previous output after that.
- R3: Mode 1 with decrypt 1 outputs D(x) XOR c, where c is the IV for the first block and the previous input block after that.
- R4: Mode 2 outputs x XOR E(ctr) for either value of the decrypt bit. After each block, bits [31:0] of ctr increment modulo 2^32 and bits [127:32] are unchanged.
- R5: Mode 3 produces no output for blocks without the last flag. For a last block with in_nbytes of 0 or 16, it outputs the tag E(chain XOR x XOR K1), where L = E(0), K1 = dbl(L) and K2 = dbl(K1). The function dbl shifts left by one bit and XORs in 0x87 when the bit shifted out is 1. After a tag, the chain restarts at zero.
- R6: In mode 3, a last block with in_nbytes n in 1..15 keeps its first n bytes and sets byte n to 0x80 and the rest to zero, then XORs the result with K2. Byte 0 is in_data[127:120].
- R7: A write to an IV word reloads the chaining/counter register from the IV. So does a control write that changes the mode field. In mode 3 the reload is to zero instead. IV words are at addresses 4..7, and address 4 holds bits [31:0].
- R8: in_ready is high only when the block is idle and the output register is empty. cph_start pulses one cycle after an input is accepted. out_valid rises one cycle after cph_done. out_data holds while out_ready is low.
- R9: Each output block sets the status bit. irq equals status AND the enable bit. Writing 1 to bit 0 of address 1 clears status, and writing 0 there has no effect.
- R10: dma_req is high exactly when in_ready or out_valid is high.
- R11: After reset, in_ready is 1, and out_valid, irq and cph_start are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Input block valid |
| in_ready | output | 1 | Controller can accept an input block |
| in_data | input | 128 | Input block, byte 0 in bits [127:120] |
| in_last | input | 1 | Final block of a CMAC message |
| in_nbytes | input | 5 | Valid bytes in a final CMAC block (0 or 16 means full) |
| out_valid | output | 1 | Output block valid |
| out_ready | input | 1 | Consumer takes the output block |
| out_data | output | 128 | Output block or CMAC tag |
| cph_start | output | 1 | One-cycle start pulse to the cipher core |
| cph_decrypt | output | 1 | Cipher direction for this call |
| cph_din | output | 128 | Cipher input block |
| cph_done | input | 1 | Cipher result valid, one cycle |
| cph_dout | input | 128 | Cipher result |
| irq | output | 1 | Completion interrupt |
| dma_req | output | 1 | DMA service request |

## Verification
The bench counts cycles from the clock edge that accepts a block. The start pulse is due one edge later. The cipher model answers after its fixed latency, and out_valid is due one edge after the cipher's done, so it arrives latency+1 edges after acceptance. The bench samples on falling edges and checks that exact count once. After that it waits for out_valid through the output handshake, so the checks do not depend on the cipher latency. For CMAC blocks without the last flag, the bench waits several cycles beyond that latency and confirms that out_valid stays low. Status and interrupt effects of a register write are checked on the falling edge after the write edge has passed.

// File: rtl/blkmode_pkg.sv
package blkmode_pkg;

   typedef enum logic [1:0] {
      MODE_ECB  = 2'd0,
      MODE_CBC  = 2'd1,
      MODE_CTR  = 2'd2,
      MODE_CMAC = 2'd3
   } chain_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SUBKEY = 2'd1,
      ST_BUSY   = 2'd2
   } seq_state_e;

   localparam int unsigned CTRL_ADDR = 0;
   localparam int unsigned STAT_ADDR = 1;

endpackage

// File: rtl/blkchain_cfg.sv
module blkchain_cfg
   import blkmode_pkg::*;
#(
   parameter int unsigned BLK_W  = 128,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              done_evt,
   output chain_mode_e       mode,
   output logic              decrypt,
   output logic [BLK_W-1:0]  iv,
   output logic              reload,
   output logic              irq
);

   localparam int unsigned WORDS   = BLK_W / DATA_W;
   localparam int unsigned IV_BASE = 1 << (ADDR_W - 1);

   chain_mode_e      mode_q;
   logic             dec_q;
   logic             en_q;
   logic             flag_q;
   logic             reload_q;
   logic [WORDS-1:0] iv_hit;
   logic             ctrl_wr;
   logic             stat_wr;

   assign ctrl_wr = reg_wr && (reg_addr == ADDR_W'(CTRL_ADDR));
   assign stat_wr = reg_wr && (reg_addr == ADDR_W'(STAT_ADDR));

   for (genvar w = 0; w < WORDS; w++) begin : g_ivword
      assign iv_hit[w] = reg_wr && (reg_addr == ADDR_W'(IV_BASE + w));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            iv[w*DATA_W +: DATA_W] <= '0;
         end else if (iv_hit[w]) begin
            iv[w*DATA_W +: DATA_W] <= reg_wdata;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q   <= MODE_ECB;
         dec_q    <= 1'b0;
         en_q     <= 1'b0;
         flag_q   <= 1'b0;
         reload_q <= 1'b0;
      end else begin
         reload_q <= (|iv_hit) || (ctrl_wr && (reg_wdata[1:0] != mode_q));
         if (ctrl_wr) begin
            mode_q <= chain_mode_e'(reg_wdata[1:0]);
            dec_q  <= reg_wdata[2];
            en_q   <= reg_wdata[3];
         end
         if (done_evt) begin
            flag_q <= 1'b1;
         end else if (stat_wr && reg_wdata[0]) begin
            flag_q <= 1'b0;
         end
      end
   end

   assign mode    = mode_q;
   assign decrypt = dec_q;
   assign reload  = reload_q;
   assign irq     = flag_q && en_q;

endmodule

// File: rtl/blkchain_dbl.sv
module blkchain_dbl #(
   parameter int unsigned BLK_W = 128
) (
   input  logic [BLK_W-1:0] val,
   output logic [BLK_W-1:0] dbl
);

   localparam logic [7:0] RED = (BLK_W == 64) ? 8'h1B : 8'h87;

   assign dbl = {val[BLK_W-2:0], 1'b0} ^ ({BLK_W{val[BLK_W-1]}} & BLK_W'(RED));

endmodule

// File: rtl/blkchain_pad.sv
module blkchain_pad #(
   parameter int unsigned BLK_W = 128,
   parameter int unsigned NB_W  = $clog2(BLK_W / 8) + 1
) (
   input  logic [BLK_W-1:0] data,
   input  logic [NB_W-1:0]  nbytes,
   output logic [BLK_W-1:0] padded,
   output logic             full
);

   localparam int unsigned NBYTES = BLK_W / 8;

   assign full = (nbytes == '0) || (nbytes >= NB_W'(NBYTES));

   for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      localparam int unsigned HI = BLK_W - 1 - 8 * b;
      assign padded[HI -: 8] = (NB_W'(b) < nbytes)  ? data[HI -: 8] :
                               (NB_W'(b) == nbytes) ? 8'h80 : 8'h00;
   end

endmodule

// File: rtl/blkchain_ctrl.sv
module blkchain_ctrl
   import blkmode_pkg::*;
#(
   parameter int unsigned BLK_W  = 128,
   parameter int unsigned CTR_W  = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 3,
   localparam int unsigned NB_W  = $clog2(BLK_W / 8) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [BLK_W-1:0]  in_data,
   input  logic              in_last,
   input  logic [NB_W-1:0]   in_nbytes,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [BLK_W-1:0]  out_data,
   output logic              cph_start,
   output logic              cph_decrypt,
   output logic [BLK_W-1:0]  cph_din,
   input  logic              cph_done,
   input  logic [BLK_W-1:0]  cph_dout,
   output logic              irq,
   output logic              dma_req
);

   initial begin
      if (BLK_W % DATA_W != 0) $fatal(1, "BLK_W must be a multiple of DATA_W");
      if (BLK_W % 8 != 0) $fatal(1, "BLK_W must be whole bytes");
      if (CTR_W > BLK_W || CTR_W == 0) $fatal(1, "CTR_W out of range");
      if (BLK_W / DATA_W > (1 << (ADDR_W - 1))) $fatal(1, "IV words exceed address space");
   end

   chain_mode_e     mode;
   logic            decrypt;
   logic            reload;
   logic [BLK_W-1:0] iv;
   logic            done_evt;

   seq_state_e      st_q;
   logic            need_sk_q;
   logic            last_q;
   logic            ov_q;
   logic            start_q;
   logic            dir_q;
   logic [BLK_W-1:0] chain_q;
   logic [BLK_W-1:0] blk_q;
   logic [BLK_W-1:0] k1_q;
   logic [BLK_W-1:0] k2_q;
   logic [BLK_W-1:0] out_q;
   logic [BLK_W-1:0] din_q;

   logic [BLK_W-1:0] pad_blk;
   logic             pad_full;
   logic [BLK_W-1:0] k1_nx;
   logic [BLK_W-1:0] k2_nx;
   logic [BLK_W-1:0] cm_blk;
   logic [BLK_W-1:0] cin;
   logic [BLK_W-1:0] res;
   logic             emit;
   logic             acc;
   logic             busy_done;

   blkchain_cfg #(.BLK_W(BLK_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .done_evt  (done_evt),
      .mode      (mode),
      .decrypt   (decrypt),
      .iv        (iv),
      .reload    (reload),
      .irq       (irq)
   );

   blkchain_pad #(.BLK_W(BLK_W), .NB_W(NB_W)) u_pad (
      .data   (in_data),
      .nbytes (in_nbytes),
      .padded (pad_blk),
      .full   (pad_full)
   );

   blkchain_dbl #(.BLK_W(BLK_W)) u_dbl1 (.val(cph_dout), .dbl(k1_nx));
   blkchain_dbl #(.BLK_W(BLK_W)) u_dbl2 (.val(k1_nx),    .dbl(k2_nx));

   assign in_ready  = (st_q == ST_IDLE) && !need_sk_q && !reload && !ov_q;
   assign acc       = in_valid && in_ready;
   assign busy_done = (st_q == ST_BUSY) && cph_done;

   always_comb begin
      if (!in_last)      cm_blk = in_data;
      else if (pad_full) cm_blk = in_data ^ k1_q;
      else               cm_blk = pad_blk ^ k2_q;
   end

   always_comb begin
      unique case (mode)
         MODE_ECB: cin = in_data;
         MODE_CBC: cin = decrypt ? in_data : (in_data ^ chain_q);
         MODE_CTR: cin = chain_q;
         default:  cin = cm_blk ^ chain_q;
      endcase
   end

   always_comb begin
      emit = 1'b1;
      unique case (mode)
         MODE_ECB: res = cph_dout;
         MODE_CBC: res = decrypt ? (cph_dout ^ chain_q) : cph_dout;
         MODE_CTR: res = cph_dout ^ blk_q;
         default: begin
            res  = cph_dout;
            emit = last_q;
         end
      endcase
   end

   assign done_evt = busy_done && emit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         need_sk_q <= 1'b0;
         last_q    <= 1'b0;
         ov_q      <= 1'b0;
         start_q   <= 1'b0;
         dir_q     <= 1'b0;
         chain_q   <= '0;
         blk_q     <= '0;
         k1_q      <= '0;
         k2_q      <= '0;
         out_q     <= '0;
         din_q     <= '0;
      end else begin
         start_q <= 1'b0;
         if (ov_q && out_ready) ov_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (need_sk_q && !reload) begin
                  start_q <= 1'b1;
                  din_q   <= '0;
                  dir_q   <= 1'b0;
                  st_q    <= ST_SUBKEY;
               end else if (acc) begin
                  start_q <= 1'b1;
                  din_q   <= cin;
                  dir_q   <= decrypt && (mode == MODE_ECB || mode == MODE_CBC);
                  blk_q   <= in_data;
                  last_q  <= in_last;
                  st_q    <= ST_BUSY;
               end
            end
            ST_SUBKEY: begin
               if (cph_done) begin
                  k1_q      <= k1_nx;
                  k2_q      <= k2_nx;
                  need_sk_q <= 1'b0;
                  st_q      <= ST_IDLE;
               end
            end
            default: begin
               if (busy_done) begin
                  unique case (mode)
                     MODE_CBC: chain_q <= decrypt ? blk_q : cph_dout;
                     MODE_CTR: chain_q[CTR_W-1:0] <= chain_q[CTR_W-1:0] + 1'b1;
                     MODE_CMAC: chain_q <= last_q ? '0 : cph_dout;
                     default: ;
                  endcase
                  if (emit) begin
                     out_q <= res;
                     ov_q  <= 1'b1;
                  end
                  st_q <= ST_IDLE;
               end
            end
         endcase
         if (reload) begin
            chain_q   <= (mode == MODE_CMAC) ? '0 : iv;
            need_sk_q <= (mode == MODE_CMAC);
         end
      end
   end

   assign out_valid   = ov_q;
   assign out_data    = out_q;
   assign cph_start   = start_q;
   assign cph_decrypt = dir_q;
   assign cph_din     = din_q;
   assign dma_req     = in_ready || ov_q;

endmodule

// File: rtl/blkchain_ctrl_chk.sv
module blkchain_ctrl_chk #(
   parameter int unsigned BLK_W = 128
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr,
   input logic             in_valid,
   input logic             in_ready,
   input logic             out_valid,
   input logic             out_ready,
   input logic [BLK_W-1:0] out_data,
   input logic             cph_start,
   input logic             cph_done,
   input logic             irq
);

   assert_start_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> cph_start);

   assert_start_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cph_start |=> !cph_start);

   assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   assert_out_after_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(cph_done));

   assert_irq_clear_by_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(reg_wr));

endmodule

bind blkchain_ctrl blkchain_ctrl_chk #(.BLK_W(BLK_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data),
   .cph_start (cph_start),
   .cph_done  (cph_done),
   .irq       (irq)
);

// File: tb/blkchain_ctrl_bench.sv
`timescale 1ns/1ps
module blkchain_ctrl_bench;

   localparam int LAT = 3;
   localparam logic [127:0] KEY = 128'h3c4f_a192_07be_55d1_e8f0_1234_9abc_def0;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         reg_wr = 1'b0;
   logic [2:0]   reg_addr = '0;
   logic [31:0]  reg_wdata = '0;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [127:0] in_data = '0;
   logic         in_last = 1'b0;
   logic [4:0]   in_nbytes = '0;
   logic         out_valid;
   logic         out_ready = 1'b0;
   logic [127:0] out_data;
   logic         cph_start;
   logic         cph_decrypt;
   logic [127:0] cph_din;
   logic         cph_done;
   logic [127:0] cph_dout;
   logic         irq;
   logic         dma_req;

   always #2.5 clk = ~clk;

   blkchain_ctrl u_blkchain_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
      .in_nbytes(in_nbytes), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .cph_start(cph_start), .cph_decrypt(cph_decrypt), .cph_din(cph_din), .cph_done(cph_done),
      .cph_dout(cph_dout), .irq(irq), .dma_req(dma_req)
   );

   function automatic logic [127:0] f_enc(logic [127:0] x);
      return {x[114:0], x[127:115]} ^ KEY;
   endfunction

   function automatic logic [127:0] f_dec(logic [127:0] y);
      logic [127:0] t;
      t = y ^ KEY;
      return {t[12:0], t[127:13]};
   endfunction

   function automatic logic [127:0] f_dbl(logic [127:0] v);
      logic [127:0] r;
      r = v << 1;
      if (v[127]) r[7:0] = r[7:0] ^ 8'h87;
      return r;
   endfunction

   function automatic logic [127:0] f_pad(logic [127:0] x, int nb);
      logic [127:0] keep;
      keep = x & ({128{1'b1}} << (128 - 8 * nb));
      return keep | (128'h80 << (120 - 8 * nb));
   endfunction

   // placeholder cipher core
   logic [2:0]   ccnt;
   logic [127:0] cbuf;
   always @(posedge clk) begin
      if (!rst_n) begin
         ccnt <= '0;
         cbuf <= '0;
      end else if (cph_start) begin
         ccnt <= 3'(LAT);
         cbuf <= cph_decrypt ? f_dec(cph_din) : f_enc(cph_din);
      end else if (ccnt != 0) begin
         ccnt <= ccnt - 1'b1;
      end
   end
   assign cph_done = (ccnt == 3'd1);
   assign cph_dout = cbuf;

   int n_cmp = 0;
   int n_bad = 0;

   logic [127:0] iv_m = '0;
   logic [127:0] chain_m = '0;
   int           mode_m = 0;
   logic         dec_m = 1'b0;

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [127:0] rnd128();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   task automatic wr_reg(input int addr, input logic [31:0] data);
      reg_wr = 1'b1;
      reg_addr = 3'(addr);
      reg_wdata = data;
      @(negedge clk);
      reg_wr = 1'b0;
      if (addr == 0) begin
         if (int'(data[1:0]) != mode_m) begin
            mode_m = int'(data[1:0]);
            chain_m = (mode_m == 3) ? '0 : iv_m;
         end
         dec_m = data[2];
      end else if (addr >= 4) begin
         iv_m[(addr-4)*32 +: 32] = data;
         chain_m = (mode_m == 3) ? '0 : iv_m;
      end
   endtask

   task automatic set_iv(input logic [127:0] v);
      for (int w = 0; w < 4; w++) wr_reg(4 + w, v[w*32 +: 32]);
   endtask

   task automatic send(input logic [127:0] x, input logic last, input int nb);
      int t;
      t = 0;
      in_data = x;
      in_last = last;
      in_nbytes = 5'(nb);
      in_valid = 1'b1;
      while (!in_ready && t < 1000) begin
         @(negedge clk);
         t++;
      end
      if (t >= 1000) chk("R8 input accept timeout", 0, 1);
      @(negedge clk);
      in_valid = 1'b0;
      in_last = 1'b0;
   endtask

   task automatic recv(output logic [127:0] d);
      int t;
      t = 0;
      while (!out_valid && t < 1000) begin
         @(negedge clk);
         t++;
      end
      if (t >= 1000) chk("R8 output timeout", 0, 1);
      d = out_data;
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
   endtask

   task automatic model_blk(input logic [127:0] x, output logic [127:0] e);
      case (mode_m)
         0: e = dec_m ? f_dec(x) : f_enc(x);
         1: begin
            if (dec_m) begin
               e = f_dec(x) ^ chain_m;
               chain_m = x;
            end else begin
               e = f_enc(x ^ chain_m);
               chain_m = e;
            end
         end
         default: begin
            e = x ^ f_enc(chain_m);
            chain_m[31:0] = chain_m[31:0] + 32'd1;
         end
      endcase
   endtask

   task automatic run_blk(input string req, input logic [127:0] x, output logic [127:0] got);
      logic [127:0] e;
      send(x, 1'b0, 16);
      recv(got);
      model_blk(x, e);
      chk(req, got, e);
   endtask

   logic [127:0] msg [4];

   task automatic run_cmac(input string req, input int n, input int nb);
      logic [127:0] l, k1, k2, c, got;
      l = f_enc('0);
      k1 = f_dbl(l);
      k2 = f_dbl(k1);
      c = '0;
      for (int i = 0; i < n - 1; i++) begin
         c = f_enc(c ^ msg[i]);
         send(msg[i], 1'b0, 16);
         repeat (LAT + 4) @(negedge clk);
         chk("R5 no output for non-last block", {127'd0, out_valid}, 128'd0);
      end
      if (nb == 0 || nb >= 16) c = f_enc(c ^ msg[n-1] ^ k1);
      else c = f_enc(c ^ f_pad(msg[n-1], nb) ^ k2);
      send(msg[n-1], 1'b1, nb);
      recv(got);
      chk(req, got, c);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      logic [127:0] got, x, ctxt [4], ptxt [4];
      int cnt;
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 reset state, R10 idle request
      chk("R11 in_ready after reset", {127'd0, in_ready}, 128'd1);
      chk("R11 out_valid after reset", {127'd0, out_valid}, 128'd0);
      chk("R11 irq after reset", {127'd0, irq}, 128'd0);
      chk("R11 cph_start after reset", {127'd0, cph_start}, 128'd0);
      chk("R10 dma_req when idle", {127'd0, dma_req}, 128'd1);

      // R1 codebook encrypt, irq disabled; latency and handshake R8, R10
      wr_reg(0, 32'h0);
      x = rnd128();
      send(x, 1'b0, 16);
      chk("R10 dma_req low while busy", {127'd0, dma_req}, 128'd0);
      cnt = 0;
      while (!out_valid && cnt < 50) begin
         @(negedge clk);
         cnt++;
      end
      chk("R8 output latency after accept", 128'(cnt), 128'(LAT + 1));
      chk("R8 in_ready low with output pending", {127'd0, in_ready}, 128'd0);
      chk("R10 dma_req with output pending", {127'd0, dma_req}, 128'd1);
      chk("R9 irq masked when disabled", {127'd0, irq}, 128'd0);
      got = out_data;
      repeat (3) @(negedge clk);
      chk("R8 output held without out_ready", out_data, got);
      recv(got);
      chk("R1 codebook encrypt", got, f_enc(x));

      // R9 enable, write-zero no effect, write-one clears
      wr_reg(0, 32'h8);
      chk("R9 irq after enabling with status set", {127'd0, irq}, 128'd1);
      wr_reg(1, 32'h0);
      chk("R9 status write of zero ignored", {127'd0, irq}, 128'd1);
      wr_reg(1, 32'h1);
      chk("R9 status write-one clears", {127'd0, irq}, 128'd0);

      for (int i = 0; i < 3; i++) run_blk("R1 codebook encrypt", rnd128(), got);
      chk("R9 irq set by completion", {127'd0, irq}, 128'd1);
      wr_reg(0, 32'hC);
      for (int i = 0; i < 3; i++) run_blk("R1 codebook decrypt", rnd128(), got);

      // R2 CBC encrypt with a fresh IV
      wr_reg(0, 32'h9);
      set_iv(rnd128());
      for (int i = 0; i < 4; i++) begin
         ptxt[i] = rnd128();
         run_blk("R2 CBC encrypt", ptxt[i], got);
         ctxt[i] = got;
      end

      // R7 rewriting the IV restarts the chain; R3 CBC decrypt recovers plaintext
      wr_reg(0, 32'hD);
      set_iv(iv_m);
      for (int i = 0; i < 4; i++) begin
         run_blk("R3 CBC decrypt", ctxt[i], got);
         chk("R3 CBC round trip", got, ptxt[i]);
      end

      // R7 same IV, same plaintext, same first ciphertext after a mode change
      wr_reg(0, 32'h8);
      wr_reg(0, 32'h9);
      run_blk("R7 chain reload on mode change", ptxt[0], got);
      chk("R7 repeat of first CBC block", got, ctxt[0]);

      // R4 counter mode with low word wrap; upper bits must not carry
      wr_reg(0, 32'hA);
      x = rnd128();
      x[31:0] = 32'hFFFF_FFFE;
      set_iv(x);
      for (int i = 0; i < 4; i++) run_blk("R4 counter mode with wrap", rnd128(), got);
      wr_reg(0, 32'hE);
      for (int i = 0; i < 2; i++) run_blk("R4 counter mode decrypt bit ignored", rnd128(), got);

      // R5 and R6 CMAC
      wr_reg(0, 32'hB);
      for (int i = 0; i < 4; i++) msg[i] = rnd128();
      run_cmac("R5 CMAC tag full last block", 3, 16);
      for (int i = 0; i < 4; i++) msg[i] = rnd128();
      run_cmac("R6 CMAC tag partial last block", 2, 1 + int'($urandom % 15));
      msg[0] = rnd128();
      run_cmac("R6 CMAC tag one byte message", 1, 1);
      msg[0] = rnd128();
      run_cmac("R6 CMAC tag fifteen byte message", 1, 15);
      msg[0] = rnd128();
      run_cmac("R5 CMAC nbytes zero means full", 1, 0);

      // random mix of the non-CMAC modes
      for (int it = 0; it < 30; it++) begin
         int m;
         m = int'($urandom % 3);
         wr_reg(0, {28'd0, 1'b1, 1'($urandom % 2), 2'(m)});
         if ($urandom % 4 == 0) wr_reg(4 + int'($urandom % 4), $urandom);
         for (int b = 0; b < 1 + int'($urandom % 3); b++)
            run_blk("R2 R3 R4 R1 random chained stream", rnd128(), got);
      end

      summary();
      $finish;
   end

endmodule